// File: doc/BRIEF.md
# Debug-Preserving Data Cache Controller

A small direct-mapped, write-back data cache placed between a processor load/store port and a plain single-word external memory port. In normal operation it keeps lines per index, fills a whole line on a miss, writes a dirty victim back before refilling, and allocates on write misses.

A debugger can freeze the cache contents while the core is halted. Two control bits are set through a separate register port. Bit 0 disables linefills and bit 1 disables eviction of valid lines. They take effect only while `debug_state` is high. In debug state every write also goes straight to external memory, so memory stays coherent without a flush. Read hits still come from the cache. An invalidate-all command walks the lines one per cycle and clears every valid and dirty bit.

Both data interfaces use valid/ready. A core request is taken on a cycle where `core_req_valid` and `core_req_ready` are both high. `core_req_ready` is high only while the controller is idle and no invalidate is being requested. The response, with read data or a write acknowledge, stays on `core_rsp_valid`/`core_rsp_rdata`, unchanged, until `core_rsp_ready` is seen. On the memory side a request stays stable until `mem_req_ready` is seen. A read then waits for a single `mem_rsp_valid` beat, which the cache always accepts. At most one memory request is in flight.

Top module: `dcache_dbg_top`

## Requirements
- R1: With `debug_state` high and control bit 0 set, a read miss issues exactly one memory read, of the requested word, and returns that word without allocating, so a repeat of the read misses again.
- R2: With `debug_state` high and control bit 1 set, a miss to an index holding a valid line leaves that line in place. The access goes to memory as a single word, and a later access to the original line still hits with no memory traffic.
- R3: In debug state a read hit returns the cached data and causes no memory traffic.
- R4: In debug state every write issues one memory write of that word. A hit also updates the cached word and leaves the dirty bit as it was. A line that is clean stays clean, so a later normal eviction writes nothing back.
- R5: With `debug_state` low, the cache behaves as in R8 and R9 whatever the control bits hold.
- R6: `reg_wr_en` loads `reg_wdata` into the control bits: bit 0 disables linefills and bit 1 disables eviction. `reg_rdata` shows the stored value from the next cycle on, and reset clears it to 0.
- R7: A pulse on `inv_req` while the controller is idle holds `core_req_ready` low for exactly LINES cycles. It then leaves every line invalid, and dirty data is discarded without a write-back, so each following access to a new line issues WORDS memory reads.
- R8: In normal mode a read miss on a dirty victim issues WORDS memory writes (write-back), then WORDS memory reads (fill), then returns the word. With a clean or invalid victim it issues only the WORDS reads. A read hit causes no traffic.
- R9: In normal mode a write hit updates the line and marks it dirty without memory traffic. A write miss allocates the line as in R8 and then applies the write.
- R10: A memory request holds its address, data and direction until accepted. A core response holds its data until accepted. The debug state and control bits are sampled when a core request is accepted.
- R11: After reset `core_req_ready` is high, `core_rsp_valid` and `mem_req_valid` are low, and all lines are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| debug_state | input | 1 | Core is halted in debug state |
| core_req_valid | input | 1 | Core request valid |
| core_req_ready | output | 1 | Controller can take a core request |
| core_req_write | input | 1 | 1 = store, 0 = load |
| core_req_addr | input | ADDR_W | Word address |
| core_req_wdata | input | DATA_W | Store data |
| core_rsp_valid | output | 1 | Response valid |
| core_rsp_ready | input | 1 | Core accepts the response |
| core_rsp_rdata | output | DATA_W | Load data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Memory word address |
| mem_req_wdata | output | DATA_W | Memory write data |
| mem_rsp_valid | input | 1 | Memory read data valid (one beat) |
| mem_rsp_rdata | input | DATA_W | Memory read data |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wdata | input | 2 | Control bits to store |
| reg_rdata | output | 2 | Stored control bits |
| inv_req | input | 1 | Invalidate-all request |

## Verification
The hardest case to reach from the ports is a debug-state miss that finds a valid line at its index, under each of the four control settings. Reaching it needs a cache already full of lines, some dirty, and addresses that collide on the same index. The bench first fills every line with normal writes. It then sweeps colliding addresses through debug state once per control setting, and predicts the memory read and write counts of every access from a bench-side model of valid, dirty and tag. Later hits and normal evictions then show whether a line was replaced or marked dirty when it should not have been.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_LOOKUP, ST_WB, ST_FILL_REQ, ST_FILL_WAIT,
    ST_BYP_REQ, ST_BYP_WAIT, ST_WT, ST_RESP, ST_INV
  } dc_state_t;

  localparam int CTL_NOFILL  = 0;
  localparam int CTL_NOEVICT = 1;

  typedef struct packed {
    logic dbg;
    logic nofill;
    logic noevict;
  } dc_mode_t;
endpackage

// File: rtl/dcache_dbg_regs.sv
module dcache_dbg_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wdata,
  output logic [1:0] ctrl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl <= '0;
    else if (wr_en) ctrl <= wdata;
  end
endmodule

// File: rtl/dcache_tag_store.sv
module dcache_tag_store #(
  parameter int LINES = 4,
  parameter int TAG_W = 6,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic             wr_dirty,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= wr_valid;
      dirty_q[wr_idx] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
endmodule

// File: rtl/dcache_data_store.sv
module dcache_data_store #(
  parameter int LINES  = 4,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(WORDS),
  localparam int DEPTH = LINES * WORDS
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] word_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) word_q[{wr_idx, wr_off}] <= wr_data;
  end

  assign rd_data = word_q[{rd_idx, rd_off}];
endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
  import dcache_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int LINES  = 4,
  parameter int WORDS  = 4,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(WORDS),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              debug_state,
  input  logic [1:0]        ctrl_bits,
  input  logic              inv_req,
  input  logic              core_req_valid,
  output logic              core_req_ready,
  input  logic              core_req_write,
  input  logic [ADDR_W-1:0] core_req_addr,
  input  logic [DATA_W-1:0] core_req_wdata,
  output logic              core_rsp_valid,
  input  logic              core_rsp_ready,
  output logic [DATA_W-1:0] core_rsp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  output logic [IDX_W-1:0]  tag_rd_idx,
  input  logic              tag_rd_valid,
  input  logic              tag_rd_dirty,
  input  logic [TAG_W-1:0]  tag_rd_tag,
  output logic              tag_wr_en,
  output logic [IDX_W-1:0]  tag_wr_idx,
  output logic              tag_wr_valid,
  output logic              tag_wr_dirty,
  output logic [TAG_W-1:0]  tag_wr_tag,
  output logic [IDX_W-1:0]  dat_rd_idx,
  output logic [OFF_W-1:0]  dat_rd_off,
  input  logic [DATA_W-1:0] dat_rd_data,
  output logic              dat_wr_en,
  output logic [IDX_W-1:0]  dat_wr_idx,
  output logic [OFF_W-1:0]  dat_wr_off,
  output logic [DATA_W-1:0] dat_wr_data,
  output dc_mode_t          cur_mode,
  output logic              inv_active
);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(WORDS - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

  dc_state_t         state_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  dc_mode_t          mode_q;
  logic [OFF_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  inv_q;

  logic [OFF_W-1:0] a_off;
  logic [IDX_W-1:0] a_idx;
  logic [TAG_W-1:0] a_tag;
  logic             hit, may_alloc, fill_beat;

  assign a_off = addr_q[OFF_W-1:0];
  assign a_idx = addr_q[OFF_W +: IDX_W];
  assign a_tag = addr_q[ADDR_W-1 -: TAG_W];

  assign hit       = tag_rd_valid && (tag_rd_tag == a_tag);
  assign may_alloc = !mode_q.nofill && !(mode_q.noevict && tag_rd_valid);
  assign fill_beat = (state_q == ST_FILL_WAIT) && mem_rsp_valid;

  assign cur_mode   = mode_q;
  assign inv_active = (state_q == ST_INV);

  // Core side
  assign core_req_ready = (state_q == ST_IDLE) && !inv_req;
  assign core_rsp_valid = (state_q == ST_RESP);
  assign core_rsp_rdata = rdata_q;

  // Memory side
  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = addr_q;
    mem_req_wdata = wdata_q;
    unique case (state_q)
      ST_WB: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = {tag_rd_tag, a_idx, cnt_q};
        mem_req_wdata = dat_rd_data;
      end
      ST_FILL_REQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = {a_tag, a_idx, cnt_q};
      end
      ST_BYP_REQ: mem_req_valid = 1'b1;
      ST_WT: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
      end
      default: ;
    endcase
  end

  // Array access
  assign tag_rd_idx = a_idx;
  assign dat_rd_idx = a_idx;
  assign dat_rd_off = (state_q == ST_WB) ? cnt_q : a_off;

  always_comb begin
    tag_wr_en    = 1'b0;
    tag_wr_idx   = a_idx;
    tag_wr_valid = 1'b1;
    tag_wr_dirty = 1'b0;
    tag_wr_tag   = a_tag;
    if (state_q == ST_INV) begin
      tag_wr_en    = 1'b1;
      tag_wr_idx   = inv_q;
      tag_wr_valid = 1'b0;
      tag_wr_tag   = '0;
    end else if (state_q == ST_LOOKUP && hit && wr_q && !mode_q.dbg) begin
      tag_wr_en    = 1'b1;
      tag_wr_dirty = 1'b1;
    end else if (fill_beat && cnt_q == LAST_OFF) begin
      tag_wr_en    = 1'b1;
    end
  end

  always_comb begin
    dat_wr_en   = 1'b0;
    dat_wr_idx  = a_idx;
    dat_wr_off  = a_off;
    dat_wr_data = wdata_q;
    if (state_q == ST_LOOKUP && hit && wr_q) begin
      dat_wr_en = 1'b1;
    end else if (fill_beat) begin
      dat_wr_en   = 1'b1;
      dat_wr_off  = cnt_q;
      dat_wr_data = mem_rsp_rdata;
    end
  end

  // Sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      mode_q  <= '0;
      cnt_q   <= '0;
      inv_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (inv_req) begin
            state_q <= ST_INV;
            inv_q   <= '0;
          end else if (core_req_valid) begin
            state_q        <= ST_LOOKUP;
            wr_q           <= core_req_write;
            addr_q         <= core_req_addr;
            wdata_q        <= core_req_wdata;
            mode_q.dbg     <= debug_state;
            mode_q.nofill  <= debug_state && ctrl_bits[CTL_NOFILL];
            mode_q.noevict <= debug_state && ctrl_bits[CTL_NOEVICT];
          end
        end
        ST_LOOKUP: begin
          cnt_q <= '0;
          if (hit) begin
            if (!wr_q) rdata_q <= dat_rd_data;
            state_q <= (wr_q && mode_q.dbg) ? ST_WT : ST_RESP;
          end else if (may_alloc) begin
            state_q <= (tag_rd_valid && tag_rd_dirty) ? ST_WB : ST_FILL_REQ;
          end else begin
            state_q <= wr_q ? ST_WT : ST_BYP_REQ;
          end
        end
        ST_WB: if (mem_req_ready) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_OFF) state_q <= ST_FILL_REQ;
        end
        ST_FILL_REQ: if (mem_req_ready) state_q <= ST_FILL_WAIT;
        ST_FILL_WAIT: if (mem_rsp_valid) begin
          cnt_q   <= cnt_q + 1'b1;
          state_q <= (cnt_q == LAST_OFF) ? ST_LOOKUP : ST_FILL_REQ;
        end
        ST_BYP_REQ: if (mem_req_ready) state_q <= ST_BYP_WAIT;
        ST_BYP_WAIT: if (mem_rsp_valid) begin
          rdata_q <= mem_rsp_rdata;
          state_q <= ST_RESP;
        end
        ST_WT: if (mem_req_ready) state_q <= ST_RESP;
        ST_RESP: if (core_rsp_ready) state_q <= ST_IDLE;
        ST_INV: begin
          inv_q <= inv_q + 1'b1;
          if (inv_q == LAST_IDX) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcache_dbg_top.sv
module dcache_dbg_top
  import dcache_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int LINES  = 4,
  parameter int WORDS  = 4,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(WORDS),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              debug_state,
  input  logic              core_req_valid,
  output logic              core_req_ready,
  input  logic              core_req_write,
  input  logic [ADDR_W-1:0] core_req_addr,
  input  logic [DATA_W-1:0] core_req_wdata,
  output logic              core_rsp_valid,
  input  logic              core_rsp_ready,
  output logic [DATA_W-1:0] core_rsp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_wdata,
  output logic [1:0]        reg_rdata,
  input  logic              inv_req
);
  logic [1:0]        ctrl_bits;
  logic [IDX_W-1:0]  tag_rd_idx, tag_wr_idx, dat_rd_idx, dat_wr_idx;
  logic              tag_rd_valid, tag_rd_dirty;
  logic [TAG_W-1:0]  tag_rd_tag, tag_wr_tag;
  logic              tag_wr_en, tag_wr_valid, tag_wr_dirty;
  logic [OFF_W-1:0]  dat_rd_off, dat_wr_off;
  logic [DATA_W-1:0] dat_rd_data, dat_wr_data;
  logic              dat_wr_en;
  dc_mode_t          cur_mode;
  logic              inv_active;

  assign reg_rdata = ctrl_bits;

  dcache_dbg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wdata(reg_wdata), .ctrl(ctrl_bits)
  );

  dcache_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(tag_rd_idx), .rd_valid(tag_rd_valid), .rd_dirty(tag_rd_dirty), .rd_tag(tag_rd_tag),
    .wr_en(tag_wr_en), .wr_idx(tag_wr_idx), .wr_valid(tag_wr_valid),
    .wr_dirty(tag_wr_dirty), .wr_tag(tag_wr_tag)
  );

  dcache_data_store #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
    .clk(clk),
    .rd_idx(dat_rd_idx), .rd_off(dat_rd_off), .rd_data(dat_rd_data),
    .wr_en(dat_wr_en), .wr_idx(dat_wr_idx), .wr_off(dat_wr_off), .wr_data(dat_wr_data)
  );

  dcache_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .debug_state(debug_state), .ctrl_bits(ctrl_bits),
    .inv_req(inv_req),
    .core_req_valid(core_req_valid), .core_req_ready(core_req_ready),
    .core_req_write(core_req_write), .core_req_addr(core_req_addr),
    .core_req_wdata(core_req_wdata),
    .core_rsp_valid(core_rsp_valid), .core_rsp_ready(core_rsp_ready),
    .core_rsp_rdata(core_rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .tag_rd_idx(tag_rd_idx), .tag_rd_valid(tag_rd_valid), .tag_rd_dirty(tag_rd_dirty),
    .tag_rd_tag(tag_rd_tag),
    .tag_wr_en(tag_wr_en), .tag_wr_idx(tag_wr_idx), .tag_wr_valid(tag_wr_valid),
    .tag_wr_dirty(tag_wr_dirty), .tag_wr_tag(tag_wr_tag),
    .dat_rd_idx(dat_rd_idx), .dat_rd_off(dat_rd_off), .dat_rd_data(dat_rd_data),
    .dat_wr_en(dat_wr_en), .dat_wr_idx(dat_wr_idx), .dat_wr_off(dat_wr_off),
    .dat_wr_data(dat_wr_data),
    .cur_mode(cur_mode), .inv_active(inv_active)
  );
endmodule

// File: rtl/dcache_dbg_chk.sv
module dcache_dbg_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_req_ready,
  input logic              core_rsp_valid,
  input logic              core_rsp_ready,
  input logic [DATA_W-1:0] core_rsp_rdata,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [DATA_W-1:0] mem_req_wdata,
  input logic              tag_wr_en,
  input logic              tag_wr_valid,
  input logic              tag_wr_dirty,
  input logic [TAG_W-1:0]  tag_wr_tag,
  input logic              tag_rd_valid,
  input logic [TAG_W-1:0]  tag_rd_tag,
  input logic              mode_dbg,
  input logic              mode_nofill,
  input logic              mode_noevict,
  input logic              inv_active
);
  AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata)); // R10

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    core_rsp_valid && !core_rsp_ready |=> core_rsp_valid && $stable(core_rsp_rdata)); // R10

  AST_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_nofill && tag_wr_en && !inv_active |-> tag_rd_valid && tag_wr_tag == tag_rd_tag); // R1

  AST_NO_EVICT: assert property (@(posedge clk) disable iff (!rst_n)
    mode_noevict && tag_wr_en && !inv_active && tag_rd_valid
      |-> tag_wr_valid && tag_wr_tag == tag_rd_tag); // R2

  AST_DBG_NO_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    mode_dbg && tag_wr_en |-> !tag_wr_dirty); // R4

  AST_INV_BLOCKS_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    inv_active |-> !core_req_ready); // R7
endmodule

bind dcache_dbg_top dcache_dbg_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .core_req_ready(core_req_ready), .core_rsp_valid(core_rsp_valid),
  .core_rsp_ready(core_rsp_ready), .core_rsp_rdata(core_rsp_rdata),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata),
  .tag_wr_en(tag_wr_en), .tag_wr_valid(tag_wr_valid), .tag_wr_dirty(tag_wr_dirty),
  .tag_wr_tag(tag_wr_tag), .tag_rd_valid(tag_rd_valid), .tag_rd_tag(tag_rd_tag),
  .mode_dbg(cur_mode.dbg), .mode_nofill(cur_mode.nofill), .mode_noevict(cur_mode.noevict),
  .inv_active(inv_active)
);

// File: tb/tb_dcache_dbg_top.sv
`timescale 1ns/1ps
module tb_dcache_dbg_top;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int LINES  = 4;
  localparam int WORDS  = 4;
  localparam int MEMSZ  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic debug_state = 1'b0;
  logic core_req_valid = 1'b0, core_req_write = 1'b0;
  logic [ADDR_W-1:0] core_req_addr = '0;
  logic [DATA_W-1:0] core_req_wdata = '0;
  logic core_req_ready, core_rsp_valid;
  logic core_rsp_ready = 1'b1;
  logic [DATA_W-1:0] core_rsp_rdata;
  logic mem_req_valid, mem_req_write;
  logic mem_req_ready = 1'b0;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [DATA_W-1:0] mem_req_wdata;
  logic mem_rsp_valid = 1'b0;
  logic [DATA_W-1:0] mem_rsp_rdata = '0;
  logic reg_wr_en = 1'b0;
  logic [1:0] reg_wdata = '0;
  logic [1:0] reg_rdata;
  logic inv_req = 1'b0;

  always #5 clk = ~clk;

  dcache_dbg_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS)) dut (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [DATA_W-1:0] bmem [MEMSZ];
  logic [DATA_W-1:0] golden [MEMSZ];
  int nrd = 0, nwr = 0;
  bit m_v [LINES];
  bit m_d [LINES];
  int m_t [LINES];
  logic [1:0] ctl_now = 2'b00;

  task automatic chk(input bit ok, input string req, input longint got, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // Memory model: handshake seen at a negedge is processed at the next one.
  initial begin
    bit pend = 0, p_wr = 0, rd_pend = 0;
    int p_a = 0, rd_a = 0, rd_lat = 0, tick = 0;
    logic [DATA_W-1:0] p_d = '0;
    forever begin
      @(negedge clk);
      if (pend) begin
        if (p_wr) begin bmem[p_a] = p_d; nwr++; end
        else begin rd_pend = 1; rd_a = p_a; rd_lat = tick % 2; nrd++; end
      end
      mem_rsp_valid = 1'b0;
      if (rd_pend) begin
        if (rd_lat == 0) begin
          mem_rsp_valid = 1'b1; mem_rsp_rdata = bmem[rd_a]; rd_pend = 0;
        end else rd_lat--;
      end
      mem_req_ready = (tick % 3) != 1;
      tick++;
      pend = mem_req_valid && mem_req_ready;
      p_wr = mem_req_write; p_a = int'(mem_req_addr); p_d = mem_req_wdata;
    end
  end

  task automatic set_ctl(input logic [1:0] v);
    @(negedge clk); #1;
    reg_wr_en = 1'b1; reg_wdata = v;
    @(negedge clk); #1;
    reg_wr_en = 1'b0; reg_wdata = ~v;
    ctl_now = v;
    chk(reg_rdata == v, "R6 control readback", reg_rdata, v);
  endtask

  task automatic access(input bit w, input int a, input logic [DATA_W-1:0] d, input int stall);
    int idx, tg, erd, ewr, rd0, wr0;
    bit hit, nf, ne, was_v, r, alloc;
    logic [DATA_W-1:0] exp_rd, got, first;
    string tag;
    idx = (a / WORDS) % LINES;
    tg  = a / (WORDS * LINES);
    hit = m_v[idx] && m_t[idx] == tg;
    was_v = m_v[idx];
    nf = debug_state && ctl_now[0];
    ne = debug_state && ctl_now[1];
    erd = 0; ewr = 0;
    if (hit) begin
      if (w) begin if (debug_state) ewr = 1; else m_d[idx] = 1; end
    end else begin
      alloc = !nf && !(ne && m_v[idx]);
      if (!alloc) begin
        if (w) ewr = 1; else erd = 1;
      end else begin
        if (m_v[idx] && m_d[idx]) ewr = WORDS;
        erd = WORDS;
        m_v[idx] = 1; m_t[idx] = tg; m_d[idx] = 0;
        if (w) begin if (debug_state) ewr += 1; else m_d[idx] = 1; end
      end
    end
    if (!debug_state && ctl_now != 0) tag = "R5";
    else if (!debug_state) tag = w ? "R9" : "R8";
    else if (hit) tag = w ? "R4" : "R3";
    else if (!w && nf) tag = "R1";
    else if (ne && was_v) tag = "R2";
    else tag = w ? "R4" : "R3";
    exp_rd = golden[a];
    if (w) golden[a] = d;

    rd0 = nrd; wr0 = nwr;
    @(negedge clk); #1;
    core_req_valid = 1'b1; core_req_write = w;
    core_req_addr = ADDR_W'(a); core_req_wdata = d;
    do begin r = core_req_ready; @(negedge clk); #1; end while (!r);
    core_req_valid = 1'b0;
    while (!core_rsp_valid) begin @(negedge clk); #1; end
    first = core_rsp_rdata;
    if (stall > 0) begin
      core_rsp_ready = 1'b0;
      repeat (stall) begin @(negedge clk); #1; end
      chk(core_rsp_valid && core_rsp_rdata == first, "R10 response held", core_rsp_rdata, first);
      core_rsp_ready = 1'b1;
    end
    got = core_rsp_rdata;
    @(negedge clk); #1;
    if (!w) chk(got == exp_rd, {tag, " read data"}, got, exp_rd);
    chk(nrd - rd0 == erd, {tag, " memory reads"}, nrd - rd0, erd);
    chk(nwr - wr0 == ewr, {tag, " memory writes"}, nwr - wr0, ewr);
    if (w && debug_state) chk(bmem[a] == d, "R4 memory updated", bmem[a], d);
  endtask

  task automatic invalidate();
    int n;
    @(negedge clk); #1;
    inv_req = 1'b1;
    @(posedge clk);
    @(negedge clk); #1;
    inv_req = 1'b0;
    n = 0;
    while (!core_req_ready && n < 100) begin n++; @(negedge clk); #1; end
    chk(n == LINES, "R7 ready low cycles", n, LINES);
    for (int i = 0; i < LINES; i++) begin m_v[i] = 0; m_d[i] = 0; end
    for (int i = 0; i < MEMSZ; i++) golden[i] = bmem[i];
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R10 watchdog expired got=0 exp=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MEMSZ; i++) begin
      bmem[i] = 32'h5000_0000 ^ (i * 7);
      golden[i] = bmem[i];
    end
    for (int i = 0; i < LINES; i++) begin m_v[i] = 0; m_d[i] = 0; m_t[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(core_req_ready == 1'b1, "R11 ready after reset", core_req_ready, 1);
    chk(core_rsp_valid == 1'b0, "R11 no response after reset", core_rsp_valid, 0);
    chk(mem_req_valid == 1'b0, "R11 no memory request after reset", mem_req_valid, 0);
    chk(reg_rdata == 2'b00, "R6 control reset value", reg_rdata, 0);

    // Normal: write sweep then read sweep over 64 words (4 tags per index)
    for (int a = 0; a < 64; a++) access(1, a, 32'hA000_0000 + a * 32'h101, 0);
    for (int a = 0; a < 64; a++) access(0, (a * 13) % 64, '0, (a % 7 == 0) ? 2 : 0);

    // Debug state under each control setting
    debug_state = 1'b1;
    for (int k = 0; k < 4; k++) begin
      set_ctl(2'(k));
      for (int i = 0; i < 32; i++) begin
        int a;
        a = (i * 5 + k * 17) % 64;
        access(i % 3 == 0, a, 32'hD000_0000 + (k << 12) + i, (i % 9 == 4) ? 1 : 0);
      end
    end
    // Repeat a no-fill read miss: must go to memory both times
    set_ctl(2'b01);
    access(0, 200, '0, 0);
    access(0, 200, '0, 0);

    // Controls set but not in debug state: normal behaviour
    debug_state = 1'b0;
    set_ctl(2'b11);
    for (int i = 0; i < 32; i++)
      access(i % 2 == 1, (i * 11) % 96, 32'hE000_0000 + i, 0);

    // Invalidate, then every line refills from memory
    invalidate();
    for (int a = 0; a < 32; a++) access(0, a * 3, '0, 0);
    invalidate();
    set_ctl(2'b00);
    for (int a = 0; a < 16; a++) access(0, a, '0, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule